// File: doc/BRIEF.md
# Deflecting Torus Router Node

This block is one node of a one-way two-dimensional torus network. Traffic arrives on two network inputs, one from the node above (north) and one from the node to the left (west). It leaves on two network outputs, toward the node to the right (east) and the node below (south). A local endpoint can offer one message per cycle on an injection port and receives messages addressed to this node on a delivery port. Each message is a single wide word that holds its destination column, its destination row and a payload. The word is never split into pieces.

The node holds no queues. Each cycle it works out where each arriving message wants to go. A message whose destination column differs from the node's own column goes east. A message in the right column whose row differs goes south. A message whose column and row both match is delivered locally. The north input is served first, then the west input, and injection comes last. The west message takes its preferred port if the north message left it free. If not, it is pushed onto a free network output, east first, so it goes round the ring again. The injected message is taken only when its own port is still free. If its port is taken, the injector is told to stall and keeps its word. Every accepted message reaches a registered output one cycle later.

The node's coordinates are parameters. The allocation uses three named routing codes: ROUTE_EAST (0), ROUTE_SOUTH (1) and ROUTE_LOCAL (2). It also uses four named source codes: SRC_NONE, SRC_NORTH, SRC_WEST and SRC_INJ. There is no sequential control state beyond the output registers.

Top module: `hop_router`

## Requirements
- R1: While reset is high, and on the first cycle after it, e_valid, s_valid and dlv_valid are all 0.
- R2: A message is a word with the destination column in bits [21:19], the destination row in bits [18:16] and the payload in bits [15:0] (default widths). A message whose column differs from MY_X, and that is not deflected, appears on the east output in the next cycle.
- R3: A message whose column equals MY_X and whose row differs from MY_Y, and that is not deflected, appears on the south output in the next cycle.
- R4: A message whose column and row equal MY_X and MY_Y, and that is not deflected, appears on the delivery output with dlv_valid high for one cycle in the next cycle. The delivery output never carries a message addressed elsewhere.
- R5: A valid north message always gets its preferred port.
- R6: A valid west message whose preferred port has been taken by the north message leaves on east if east is free, and otherwise on south.
- R7: No message is dropped. The number of valid outputs in a cycle equals the number of network messages plus granted injections in the cycle before.
- R8: An injected message is granted only when its preferred port is still free after both network inputs are served. Otherwise inj_stall is high in the same cycle and the message appears on no output.
- R9: Every message leaves the node bit for bit unchanged.
- R10: When no input is valid, no output is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| n_valid | input | 1 | North input carries a message |
| n_msg | input | MSG_W | North input message |
| w_valid | input | 1 | West input carries a message |
| w_msg | input | MSG_W | West input message |
| inj_valid | input | 1 | Local endpoint offers a message |
| inj_msg | input | MSG_W | Offered local message |
| inj_stall | output | 1 | Offered message not taken this cycle |
| e_valid | output | 1 | East output carries a message |
| e_msg | output | MSG_W | East output message |
| s_valid | output | 1 | South output carries a message |
| s_msg | output | MSG_W | South output message |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_msg | output | MSG_W | Delivered message |

## Verification
Every decision in this node is made within one cycle, so a wrong route code or a wrong allocation shows at the registered outputs on the very next edge. The fault appears as a message on the wrong port, a missing valid that breaks the count of messages in against messages out, or a wrong word on a valid port. A wrong injection grant shows at once on inj_stall and one cycle later as an extra or missing output. The directed cases cover the collisions that force deflection. The random traffic covers the mixed patterns that the directed cases do not.

// File: rtl/hop_pkg.sv
package hop_pkg;

    typedef enum logic [1:0] {
        ROUTE_EAST  = 2'd0,
        ROUTE_SOUTH = 2'd1,
        ROUTE_LOCAL = 2'd2
    } route_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_NORTH = 2'd1,
        SRC_WEST  = 2'd2,
        SRC_INJ   = 2'd3
    } src_t;

endpackage

// File: rtl/hop_route.sv
module hop_route
    import hop_pkg::*;
#(
    parameter int X_W       = 3,
    parameter int Y_W       = 3,
    parameter int PAYLOAD_W = 16,
    parameter int MY_X      = 2,
    parameter int MY_Y      = 5,
    localparam int MSG_W    = X_W + Y_W + PAYLOAD_W
) (
    input  logic [MSG_W-1:0] msg,
    output route_t           route
);
    localparam int XHI = MSG_W - 1;
    localparam int YHI = MSG_W - 1 - X_W;
    localparam logic [X_W-1:0] HERE_X = X_W'(MY_X);
    localparam logic [Y_W-1:0] HERE_Y = Y_W'(MY_Y);

    logic [X_W-1:0] dst_x;
    logic [Y_W-1:0] dst_y;

    assign dst_x = msg[XHI -: X_W];
    assign dst_y = msg[YHI -: Y_W];

    // Column first, then row.
    always_comb begin
        if (dst_x != HERE_X)      route = ROUTE_EAST;
        else if (dst_y != HERE_Y) route = ROUTE_SOUTH;
        else                      route = ROUTE_LOCAL;
    end

    logic unused_payload;
    assign unused_payload = ^msg[PAYLOAD_W-1:0];
endmodule

// File: rtl/hop_alloc.sv
module hop_alloc
    import hop_pkg::*;
(
    input  logic   n_v,
    input  route_t n_want,
    input  logic   w_v,
    input  route_t w_want,
    input  logic   i_v,
    input  route_t i_want,
    output src_t   sel_e,
    output src_t   sel_s,
    output src_t   sel_l,
    output logic   inj_grant
);
    logic [2:0] busy;
    src_t       sel [3];
    logic [1:0] w_pick;

    always_comb begin
        busy      = '0;
        sel[0]    = SRC_NONE;
        sel[1]    = SRC_NONE;
        sel[2]    = SRC_NONE;
        inj_grant = 1'b0;
        w_pick    = 2'd0;

        // North has first claim.
        if (n_v) begin
            busy[n_want] = 1'b1;
            sel[n_want]  = SRC_NORTH;
        end

        // West takes its port, or is deflected east, then south.
        if (w_v) begin
            if (!busy[w_want])                   w_pick = w_want;
            else if (!busy[ROUTE_EAST])          w_pick = ROUTE_EAST;
            else                                 w_pick = ROUTE_SOUTH;
            busy[w_pick] = 1'b1;
            sel[w_pick]  = SRC_WEST;
        end

        // Injection only fills a port that is still free.
        if (i_v && !busy[i_want]) begin
            busy[i_want] = 1'b1;
            sel[i_want]  = SRC_INJ;
            inj_grant    = 1'b1;
        end
    end

    assign sel_e = sel[0];
    assign sel_s = sel[1];
    assign sel_l = sel[2];
endmodule

// File: rtl/hop_router.sv
module hop_router
    import hop_pkg::*;
#(
    parameter int X_W       = 3,
    parameter int Y_W       = 3,
    parameter int PAYLOAD_W = 16,
    parameter int MY_X      = 2,
    parameter int MY_Y      = 5,
    localparam int MSG_W    = X_W + Y_W + PAYLOAD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             n_valid,
    input  logic [MSG_W-1:0] n_msg,
    input  logic             w_valid,
    input  logic [MSG_W-1:0] w_msg,
    input  logic             inj_valid,
    input  logic [MSG_W-1:0] inj_msg,
    output logic             inj_stall,
    output logic             e_valid,
    output logic [MSG_W-1:0] e_msg,
    output logic             s_valid,
    output logic [MSG_W-1:0] s_msg,
    output logic             dlv_valid,
    output logic [MSG_W-1:0] dlv_msg
);
    localparam int NUM_IN = 3;

    logic [MSG_W-1:0] in_msg  [NUM_IN];
    route_t           in_want [NUM_IN];

    assign in_msg[0] = n_msg;
    assign in_msg[1] = w_msg;
    assign in_msg[2] = inj_msg;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_route
        hop_route #(
            .X_W(X_W), .Y_W(Y_W), .PAYLOAD_W(PAYLOAD_W),
            .MY_X(MY_X), .MY_Y(MY_Y)
        ) u_route (
            .msg   (in_msg[g]),
            .route (in_want[g])
        );
    end

    src_t sel_e, sel_s, sel_l;
    logic inj_grant;

    hop_alloc u_alloc (
        .n_v       (n_valid),
        .n_want    (in_want[0]),
        .w_v       (w_valid),
        .w_want    (in_want[1]),
        .i_v       (inj_valid),
        .i_want    (in_want[2]),
        .sel_e     (sel_e),
        .sel_s     (sel_s),
        .sel_l     (sel_l),
        .inj_grant (inj_grant)
    );

    assign inj_stall = inj_valid & ~inj_grant;

    function automatic logic [MSG_W-1:0] pick_msg(
        input src_t             s,
        input logic [MSG_W-1:0] a,
        input logic [MSG_W-1:0] b,
        input logic [MSG_W-1:0] c
    );
        unique case (s)
            SRC_NORTH: return a;
            SRC_WEST:  return b;
            SRC_INJ:   return c;
            default:   return '0;
        endcase
    endfunction

    logic             e_v_d, s_v_d, l_v_d;
    logic [MSG_W-1:0] e_m_d, s_m_d, l_m_d;

    always_comb begin
        e_v_d = (sel_e != SRC_NONE);
        s_v_d = (sel_s != SRC_NONE);
        l_v_d = (sel_l != SRC_NONE);
        e_m_d = pick_msg(sel_e, n_msg, w_msg, inj_msg);
        s_m_d = pick_msg(sel_s, n_msg, w_msg, inj_msg);
        l_m_d = pick_msg(sel_l, n_msg, w_msg, inj_msg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid   <= 1'b0;
            s_valid   <= 1'b0;
            dlv_valid <= 1'b0;
            e_msg     <= '0;
            s_msg     <= '0;
            dlv_msg   <= '0;
        end else begin
            e_valid   <= e_v_d;
            s_valid   <= s_v_d;
            dlv_valid <= l_v_d;
            e_msg     <= e_m_d;
            s_msg     <= s_m_d;
            dlv_msg   <= l_m_d;
        end
    end
endmodule

// File: rtl/hop_router_chk.sv
module hop_router_chk #(
    parameter int X_W       = 3,
    parameter int Y_W       = 3,
    parameter int PAYLOAD_W = 16,
    parameter int MY_X      = 2,
    parameter int MY_Y      = 5,
    localparam int MSG_W    = X_W + Y_W + PAYLOAD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             n_valid,
    input logic [MSG_W-1:0] n_msg,
    input logic             w_valid,
    input logic             inj_valid,
    input logic             inj_stall,
    input logic             e_valid,
    input logic [MSG_W-1:0] e_msg,
    input logic             s_valid,
    input logic             dlv_valid,
    input logic [MSG_W-1:0] dlv_msg
);
    localparam int XHI = MSG_W - 1;
    localparam int YHI = MSG_W - 1 - X_W;

    logic [1:0] offered;
    logic       n_off_col;
    assign offered   = 2'(n_valid) + 2'(w_valid) + 2'(inj_valid & ~inj_stall);
    assign n_off_col = n_valid && (n_msg[XHI -: X_W] != X_W'(MY_X));

    assert_conserve_R7: assert property (@(posedge clk) disable iff (rst)
        2'($countones({e_valid, s_valid, dlv_valid})) == $past(offered));

    assert_north_east_R5: assert property (@(posedge clk) disable iff (rst)
        n_off_col |=> (e_valid && e_msg == $past(n_msg)));

    assert_deliver_here_R4: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> (dlv_msg[XHI -: X_W] == X_W'(MY_X) &&
                       dlv_msg[YHI -: Y_W] == Y_W'(MY_Y)));

    assert_stall_only_offered_R8: assert property (@(posedge clk) disable iff (rst)
        inj_stall |-> inj_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!n_valid && !w_valid && !inj_valid) |=> !(e_valid || s_valid || dlv_valid));
endmodule

bind hop_router hop_router_chk #(
    .X_W(X_W), .Y_W(Y_W), .PAYLOAD_W(PAYLOAD_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
    .clk(clk), .rst(rst), .n_valid(n_valid), .n_msg(n_msg),
    .w_valid(w_valid), .inj_valid(inj_valid), .inj_stall(inj_stall),
    .e_valid(e_valid), .e_msg(e_msg), .s_valid(s_valid),
    .dlv_valid(dlv_valid), .dlv_msg(dlv_msg)
);

// File: tb/hop_router_test.sv
module hop_router_test;
    localparam int X_W = 3, Y_W = 3, PW = 16, MX = 2, MY = 5;
    localparam int MSG_W = X_W + Y_W + PW;

    logic clk = 1'b0, rst = 1'b1;
    logic n_valid = 0, w_valid = 0, inj_valid = 0;
    logic [MSG_W-1:0] n_msg = '0, w_msg = '0, inj_msg = '0;
    logic inj_stall, e_valid, s_valid, dlv_valid;
    logic [MSG_W-1:0] e_msg, s_msg, dlv_msg;

    always #10 clk = ~clk;

    hop_router #(.X_W(X_W), .Y_W(Y_W), .PAYLOAD_W(PW), .MY_X(MX), .MY_Y(MY)) uut (
        .clk(clk), .rst(rst), .n_valid(n_valid), .n_msg(n_msg),
        .w_valid(w_valid), .w_msg(w_msg), .inj_valid(inj_valid), .inj_msg(inj_msg),
        .inj_stall(inj_stall), .e_valid(e_valid), .e_msg(e_msg),
        .s_valid(s_valid), .s_msg(s_msg), .dlv_valid(dlv_valid), .dlv_msg(dlv_msg)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    logic             xv [3];
    logic [MSG_W-1:0] xm [3];
    logic             x_stall;
    bit               have_exp = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MSG_W-1:0] mk(input int x, input int y, input int p);
        return {X_W'(x), Y_W'(y), PW'(p)};
    endfunction

    // 0 east, 1 south, 2 local
    function automatic int want(input logic [MSG_W-1:0] m);
        if (m[MSG_W-1 -: X_W] != X_W'(MX)) return 0;
        if (m[MSG_W-1-X_W -: Y_W] != Y_W'(MY)) return 1;
        return 2;
    endfunction

    // Expected outputs from the requirements (R2..R9).
    task automatic model();
        bit busy [3];
        int p;
        for (int k = 0; k < 3; k++) begin busy[k] = 0; xv[k] = 0; xm[k] = '0; end
        x_stall = 0;
        if (n_valid) begin p = want(n_msg); busy[p] = 1; xv[p] = 1; xm[p] = n_msg; end
        if (w_valid) begin
            p = want(w_msg);
            if (busy[p]) p = busy[0] ? 1 : 0;
            busy[p] = 1; xv[p] = 1; xm[p] = w_msg;
        end
        if (inj_valid) begin
            p = want(inj_msg);
            if (busy[p]) x_stall = 1;
            else begin busy[p] = 1; xv[p] = 1; xm[p] = inj_msg; end
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(e_valid === xv[0], {tag, " R2 R6 R7 e_valid"}, 64'(e_valid), 64'(xv[0]));
        chk(s_valid === xv[1], {tag, " R3 R6 R7 s_valid"}, 64'(s_valid), 64'(xv[1]));
        chk(dlv_valid === xv[2], {tag, " R4 R7 dlv_valid"}, 64'(dlv_valid), 64'(xv[2]));
        if (xv[0]) chk(e_msg === xm[0], {tag, " R9 e_msg"}, 64'(e_msg), 64'(xm[0]));
        if (xv[1]) chk(s_msg === xm[1], {tag, " R9 s_msg"}, 64'(s_msg), 64'(xm[1]));
        if (xv[2]) chk(dlv_msg === xm[2], {tag, " R9 dlv_msg"}, 64'(dlv_msg), 64'(xm[2]));
    endtask

    // One cycle: drive at negedge, check stall, check outputs at next negedge.
    task automatic step(input bit nv, input logic [MSG_W-1:0] nm,
                        input bit wv, input logic [MSG_W-1:0] wm,
                        input bit iv, input logic [MSG_W-1:0] im, input string tag);
        @(negedge clk);
        n_valid = nv; n_msg = nm; w_valid = wv; w_msg = wm; inj_valid = iv; inj_msg = im;
        #1;
        model();
        chk(inj_stall === x_stall, {tag, " R8 inj_stall"}, 64'(inj_stall), 64'(x_stall));
        @(negedge clk);
        check_outputs(tag);
        n_valid = 0; w_valid = 0; inj_valid = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        logic [MSG_W-1:0] none = '0;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(!e_valid && !s_valid && !dlv_valid, "R1 during reset", 64'({e_valid, s_valid, dlv_valid}), 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        chk(!e_valid && !s_valid && !dlv_valid, "R1 after reset", 64'({e_valid, s_valid, dlv_valid}), 0);

        // Directed corner cases
        step(0, none, 0, none, 0, none, "R10 idle");
        step(1, mk(6, 0, 16'h1111), 0, none, 0, none, "R2 north east");
        step(0, none, 1, mk(2, 1, 16'h2222), 0, none, "R3 west south");
        step(0, none, 1, mk(2, 5, 16'h3333), 0, none, "R4 west deliver");
        step(1, mk(2, 3, 16'hA1), 1, mk(2, 7, 16'hA2), 0, none, "R5 R6 both south");
        step(1, mk(2, 5, 16'hB1), 1, mk(2, 5, 16'hB2), 0, none, "R5 R6 both local");
        step(1, mk(0, 0, 16'hC1), 1, mk(1, 1, 16'hC2), 0, none, "R6 both east");
        step(1, mk(2, 1, 16'hD1), 1, mk(4, 1, 16'hD2), 1, mk(5, 0, 16'hD3), "R8 inject blocked");
        step(1, mk(2, 1, 16'hE1), 0, none, 1, mk(5, 0, 16'hE3), "R8 inject east");
        step(0, none, 0, none, 1, mk(2, 5, 16'hF3), "R8 inject local");
        step(1, mk(2, 5, 16'h71), 0, none, 1, mk(2, 5, 16'h73), "R8 local taken");
        step(0, none, 0, none, 0, none, "R10 idle again");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            bit nv = ($urandom % 10) < 6;
            bit wv = ($urandom % 10) < 6;
            bit iv = ($urandom % 10) < 5;
            int nx = (($urandom % 4) == 0) ? int'($urandom % 8) : MX;
            int ny = (($urandom % 3) == 0) ? MY : int'($urandom % 8);
            step(nv, mk(nx, ny, int'($urandom)),
                 wv, mk(int'($urandom % 8), int'($urandom % 8), int'($urandom)),
                 iv, mk(int'($urandom % 8), int'($urandom % 8), int'($urandom)),
                 "random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule